// File: doc/BRIEF.md
# Bursty Serial Byte Receiver

This block accepts a compressed bitstream from a host over two wires only: a bit clock and a data line. There is no frame or word strobe. The bits are treated as one unbroken stream. Every eight bits, in arrival order, form a byte, and a burst may stop and resume at any bit. Completed bytes cross into the system clock domain through a dual-clock FIFO with Gray-coded pointers. The system side reads them through a first-word-fall-through port with an empty flag.

Flow control runs on a single output line, `burst_stop`. While the FIFO holds fewer bytes than a threshold, the line stays low and the host may send another burst. Once occupancy reaches the threshold, the line goes high and the host must pause. Because of this, the mode suits asynchronous delivery, where data arrives in bursts on demand and not at a fixed rate. It cannot carry PCM samples, since no word boundaries exist. A byte that completes while the FIFO is full is discarded and counted.

Each clock domain has its own synchronous active-high reset. Together the two resets clear the FIFO, the bit counter, the partial byte and the overflow record, and drive `burst_stop` low.

Top module: `burst_rx_top`

## Requirements
- R1: After reset, `empty` is 1, `burst_stop` is 0, `ovf_flag` is 0 and `ovf_count` is 0.
- R2: Data is sampled on the rising edge of `bclk`, and the first bit of each byte lands in bit 7 (MSB first).
- R3: Bytes are cut from a continuous bit stream: every eighth bit since reset closes a byte, whatever pauses the bit clock takes between bits.
- R4: Bytes are read out in arrival order. While `empty` is 0, `rd_data` shows the oldest byte, and `rd_en` high at a rising `clk` edge removes it.
- R5: `empty` is 1 exactly when no byte is held. A read request while `empty` is 1 removes nothing: the next byte written is still the next byte read.
- R6: `burst_stop` is 1 when the FIFO holds at least THRESH bytes (default 8 of 16) and 0 when it holds fewer.
- R7: A byte that completes while the FIFO is full (16 bytes by default) is dropped. The held bytes stay intact, `ovf_count` rises by one (saturating) and `ovf_flag` is set and stays set until reset.
- R8: Reset in the middle of a byte discards the bits already received, so the next eight bits form a fresh byte.
- R9: When reads take occupancy back below THRESH, `burst_stop` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (read side) |
| rst | input | 1 | Synchronous active-high reset, clk domain |
| bclk | input | 1 | Bursty serial bit clock from the host |
| brst | input | 1 | Synchronous active-high reset, bclk domain |
| sdata | input | 1 | Serial data, sampled on rising bclk |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the FIFO |
| empty | output | 1 | No byte held |
| burst_stop | output | 1 | High when occupancy is at or above threshold; host must pause |
| ovf_flag | output | 1 | Sticky: a byte was dropped on a full FIFO |
| ovf_count | output | OVF_W | Saturating count of dropped bytes |

## Verification
The bench splits one byte across two bursts. A receiver that restarts its bit count at each burst would emit a wrong byte there. It also resets the receiver after three stray bits: a design that keeps the partial byte would return the next byte shifted. The FIFO is then driven past full. Wrong full detection would show up as overwritten head bytes or a miscounted drop total. Finally, `burst_stop` is followed across the threshold in both directions, which exposes an off-by-one in the comparison, and a pop on an empty FIFO is tried to catch pointer underflow.

// File: rtl/burst_rx_pkg.sv
package burst_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // A byte completing at the current bit-clock edge
    typedef struct packed {
        logic  vld;
        byte_t data;
    } byte_evt_t;

endpackage

// File: rtl/burst_rx_sync.sv
module burst_rx_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/burst_rx_packer.sv
module burst_rx_packer
    import burst_rx_pkg::*;
(
    input  logic      bclk,
    input  logic      brst,
    input  logic      sdata,
    output byte_evt_t evt
);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    shreg;

    always_ff @(posedge bclk) begin
        if (brst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_W-3:0], sdata};
        end
    end

    // Byte completes on the edge that samples its eighth bit
    always_comb begin
        evt.vld  = !brst && (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
        evt.data = {shreg, sdata};
    end

endmodule

// File: rtl/burst_rx_fifo.sv
module burst_rx_fifo
    import burst_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic          bclk,
    input  logic          brst,
    input  byte_evt_t     wr_evt,
    output logic          wr_drop,
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    output byte_t         rd_data,
    output logic          empty,
    output logic [PW-1:0] rd_bin,
    output logic [PW-1:0] wr_bin_sync
);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    byte_t         mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rgray, rgray_w, wgray_r;
    logic          wfull, push, pop;

    // ---------------- write side (bclk) ----------------
    burst_rx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk (bclk), .rst (brst), .d (rgray), .q (rgray_w)
    );

    assign wfull   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign push    = wr_evt.vld && !wfull;
    assign wr_drop = wr_evt.vld && wfull;

    always_ff @(posedge bclk) begin
        if (brst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    always_ff @(posedge bclk) begin
        if (push) mem[wbin[AW-1:0]] <= wr_evt.data;
    end

    // ---------------- read side (clk) ----------------
    burst_rx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk (clk), .rst (rst), .d (wgray), .q (wgray_r)
    );

    assign empty = (rgray == wgray_r);
    assign pop   = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin <= '0;
            rgray  <= '0;
        end else if (pop) begin
            rd_bin <= rd_bin + 1'b1;
            rgray  <= to_gray(rd_bin + 1'b1);
        end
    end

    assign rd_data     = mem[rd_bin[AW-1:0]];
    assign wr_bin_sync = from_gray(wgray_r);

endmodule

// File: rtl/burst_rx_level.sv
module burst_rx_level #(
    parameter int AW     = 4,
    parameter int THRESH = 8,
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_bin_sync,
    input  logic [PW-1:0] rd_bin,
    output logic          stop
);

    logic [PW-1:0] occ;

    assign occ = wr_bin_sync - rd_bin;

    always_ff @(posedge clk) begin
        if (rst) stop <= 1'b0;
        else     stop <= (occ >= PW'(THRESH));
    end

endmodule

// File: rtl/burst_rx_top.sv
module burst_rx_top
    import burst_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int THRESH      = DEPTH / 2,
    parameter int SYNC_STAGES = 2,
    parameter int OVF_W       = 8,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk,
    input  logic             brst,
    input  logic             sdata,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic             burst_stop,
    output logic             ovf_flag,
    output logic [OVF_W-1:0] ovf_count
);

    byte_evt_t     evt;
    logic          wr_drop;
    logic [PW-1:0] rd_bin, wr_bin_sync;

    burst_rx_packer u_packer (
        .bclk (bclk), .brst (brst), .sdata (sdata), .evt (evt)
    );

    burst_rx_fifo #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .bclk        (bclk),
        .brst        (brst),
        .wr_evt      (evt),
        .wr_drop     (wr_drop),
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .empty       (empty),
        .rd_bin      (rd_bin),
        .wr_bin_sync (wr_bin_sync)
    );

    burst_rx_level #(.AW(AW), .THRESH(THRESH)) u_level (
        .clk         (clk),
        .rst         (rst),
        .wr_bin_sync (wr_bin_sync),
        .rd_bin      (rd_bin),
        .stop        (burst_stop)
    );

    // Drop record lives in the bit-clock domain
    always_ff @(posedge bclk) begin
        if (brst) begin
            ovf_flag  <= 1'b0;
            ovf_count <= '0;
        end else if (wr_drop) begin
            ovf_flag <= 1'b1;
            if (ovf_count != '1) ovf_count <= ovf_count + 1'b1;
        end
    end

endmodule

// File: rtl/burst_rx_chk.sv
module burst_rx_chk #(
    parameter int AW    = 4,
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk,
    input logic             brst,
    input logic             rd_en,
    input logic             empty,
    input logic             burst_stop,
    input logic             ovf_flag,
    input logic [OVF_W-1:0] ovf_count,
    input logic             wr_drop,
    input logic [AW:0]      rd_bin
);

    assert_rd_reset_R1: assert property (@(posedge clk)
        rst |=> (empty && !burst_stop));

    assert_wr_reset_R1: assert property (@(posedge bclk)
        brst |=> (!ovf_flag && ovf_count == '0));

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |=> (rd_bin == $past(rd_bin)));

    assert_stop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        burst_stop |-> !empty);

    assert_drop_flag_R7: assert property (@(posedge bclk) disable iff (brst)
        wr_drop |=> ovf_flag);

    assert_flag_sticky_R7: assert property (@(posedge bclk) disable iff (brst)
        ovf_flag |=> ovf_flag);

    assert_count_step_R7: assert property (@(posedge bclk) disable iff (brst)
        !brst |=> (ovf_count == $past(ovf_count) || ovf_count == $past(ovf_count) + 1'b1));

endmodule

bind burst_rx_top burst_rx_chk #(.AW(AW), .OVF_W(OVF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bclk       (bclk),
    .brst       (brst),
    .rd_en      (rd_en),
    .empty      (empty),
    .burst_stop (burst_stop),
    .ovf_flag   (ovf_flag),
    .ovf_count  (ovf_count),
    .wr_drop    (wr_drop),
    .rd_bin     (rd_bin)
);

// File: tb/tb_burst_rx_top.sv
module tb_burst_rx_top;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_HALF   = 7;
    localparam int NVEC       = 8;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'h00, 8'hFF,
                                          8'h81, 8'h5A, 8'h7E, 8'h01};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       brst = 1'b1;
    logic       sdata = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       empty, burst_stop, ovf_flag;
    logic [7:0] ovf_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rx_top dut (
        .clk (clk), .rst (rst), .bclk (bclk), .brst (brst), .sdata (sdata),
        .rd_en (rd_en), .rd_data (rd_data), .empty (empty),
        .burst_stop (burst_stop), .ovf_flag (ovf_flag), .ovf_count (ovf_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        #(BIT_HALF) bclk = 1'b1;
        #(BIT_HALF) bclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; brst = 1'b1;
        send_bit(1'b1); send_bit(1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0; brst = 1'b0; sdata = 1'b0;
        settle();
    endtask

    task automatic pop_check(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(req, int'(empty), 0);
        chk(req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 burst_stop", int'(burst_stop), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        chk("R1 ovf_count", int'(ovf_count), 0);

        // R2/R6 vector table: one byte per burst, threshold tracked
        for (int i = 0; i < NVEC; i++) begin
            send_byte(VEC[i]);
            settle();
            chk("R6 stop vs level", int'(burst_stop), (i + 1 >= 8) ? 1 : 0);
        end
        for (int i = 0; i < NVEC; i++) pop_check(VEC[i], "R2 R4 order");
        chk("R5 empty after drain", int'(empty), 1);
        chk("R9 stop after drain", int'(burst_stop), 0);

        // R5 pop while empty removes nothing
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        send_byte(8'h42);
        settle();
        pop_check(8'h42, "R5 empty pop ignored");
        chk("R5 empty", int'(empty), 1);

        // R3 byte split across two bursts: 16'hC3E1 as 5 + 11 bits
        for (int i = 15; i >= 11; i--) send_bit(16'hC3E1 >> i);
        settle();
        chk("R3 no byte after 5 bits", int'(empty), 1);
        for (int i = 10; i >= 0; i--) send_bit(16'hC3E1 >> i);
        settle();
        pop_check(8'hC3, "R3 first byte");
        pop_check(8'hE1, "R3 second byte");

        // R8 reset mid-byte
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        do_reset();
        send_byte(8'h0F);
        settle();
        pop_check(8'h0F, "R8 fresh byte");
        chk("R8 nothing extra", int'(empty), 1);

        // R7 overflow, R9 threshold fall
        do_reset();
        for (int i = 0; i < 16; i++) send_byte(8'(i * 3 + 1));
        settle();
        chk("R7 no drop when filling", int'(ovf_count), 0);
        send_byte(8'hEE);
        send_byte(8'hDD);
        settle();
        chk("R7 ovf_count", int'(ovf_count), 2);
        chk("R7 ovf_flag", int'(ovf_flag), 1);
        for (int i = 0; i < 16; i++) begin
            pop_check(8'(i * 3 + 1), "R7 contents intact");
            chk("R9 stop follows level", int'(burst_stop), (15 - i >= 8) ? 1 : 0);
        end
        chk("R7 dropped bytes absent", int'(empty), 1);
        chk("R7 flag sticky", int'(ovf_flag), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule